// File: doc/BRIEF.md
# Dual-Stream Result Output Formatter

This block sits at the back of a complex datapath and turns its raw results into words on two 24-bit output lanes, one for the real part and one for the imaginary part. Every result carries a 48-bit value per lane plus a 2-bit mode and a zero-force flag. In the two wide-accumulation modes (magnitude-squared and FIR), each lane's 48-bit value is sent as two 24-bit words on consecutive transfers, the upper word first. In the other modes each lane is rounded to 24 bits, and both lanes go out together in a single transfer.

Both sides use valid/ready handshakes. A result is accepted on a clock edge where `in_valid` and `in_ready` are both high. An output word is consumed on an edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the presented word and its flags stay frozen. A one-entry holding slot sits between the two sides. `in_ready` is high whenever the slot is empty or is being drained in the same cycle, so `in_ready` can depend combinationally on `out_ready`. The mode and zero flag travel with each result, so a mode change between results can never split a wide transfer.

Top module: `dual_stream_fmt`

## Requirements
- R1: After a synchronous active-high reset, `out_valid` is 0 and `in_ready` is 1.
- R2: In a narrow mode, each lane's output word is the signed upper 24 bits of its 48-bit input plus the bit just below them (bit 23), that is, a half-LSB round-up.
- R3: If the upper 24 bits equal 0x7FFFFF and bit 23 is set, the rounded word saturates at 0x7FFFFF instead of wrapping.
- R4: In a wide mode, a result produces two words. The first carries bits 47:24 of each lane with `out_hi`=1 and `out_wide`=1. The next transfer carries bits 23:0 with `out_hi`=0 and `out_wide`=1. Narrow words have `out_hi`=0 and `out_wide`=0.
- R5: The mode codes are 2'b01 (magnitude-squared) and 2'b10 (FIR), which are wide. Codes 2'b00 and 2'b11 are narrow.
- R6: When `in_zero` is 1 with a result, every word of that result is zero on both lanes. The word count and the `out_hi`/`out_wide` flags are the same as without it.
- R7: While `out_valid`=1 and `out_ready`=0, `out_re`, `out_im`, `out_hi` and `out_wide` keep their values and `out_valid` stays 1.
- R8: With `out_ready` held at 1, narrow results flow at one per cycle and wide results at one per two cycles, with no idle output cycle in a mixed stream. Order is preserved and nothing is lost. `in_ready` is 1 whenever `out_valid` is 0.
- R9: An accepted result appears on the outputs one edge after acceptance if the output stage is free. A result offered while `in_ready`=0 is not taken and never reaches the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A result is offered |
| in_ready | output | 1 | The block can take a result this cycle |
| in_mode | input | 2 | Result mode (R5) |
| in_zero | input | 1 | Force this result's output words to zero |
| in_re | input | 48 | Real-lane raw result |
| in_im | input | 48 | Imaginary-lane raw result |
| out_valid | output | 1 | An output word is presented |
| out_ready | input | 1 | The consumer takes the presented word |
| out_re | output | 24 | Real-lane output word |
| out_im | output | 24 | Imaginary-lane output word |
| out_hi | output | 1 | The word is the upper half of a wide result |
| out_wide | output | 1 | The word belongs to a wide result |

## Verification
If the pending-low-half flag were lost or set by mistake, the error would show on the very next consumed transfer. Either an upper word would be followed by a new result instead of its lower half, or a stale lower half would be repeated. If the holding slot were mishandled, a mixed stream would come out short, reordered or with a gap within a few cycles of the first back-pressure or wide result. A rounding or saturation fault changes the word presented one edge after acceptance.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

  typedef enum logic [1:0] {
    MODE_ROUND     = 2'b00,
    MODE_MAGSQ     = 2'b01,
    MODE_FIR       = 2'b10,
    MODE_ROUND_ALT = 2'b11
  } fmt_mode_e;

  localparam int NUM_LANES = 2;

  function automatic logic mode_is_wide(input logic [1:0] mode);
    return (mode == MODE_MAGSQ) || (mode == MODE_FIR);
  endfunction

endpackage

// File: rtl/fmt_rounder.sv
module fmt_rounder #(
  parameter int WORD_W = 24
) (
  input  logic [2*WORD_W-1:0] acc_i,
  output logic [WORD_W-1:0]   word_o
);
  localparam int ACC_W = 2 * WORD_W;
  localparam logic [WORD_W-1:0] MAX_POS = {1'b0, {(WORD_W-1){1'b1}}};

  logic [WORD_W-1:0] upper;
  logic              half;

  always_comb begin
    upper = acc_i[ACC_W-1 -: WORD_W];
    half  = acc_i[WORD_W-1];
    if (half && (upper == MAX_POS)) begin
      word_o = MAX_POS;
    end else begin
      word_o = upper + {{(WORD_W-1){1'b0}}, half};
    end
  end
endmodule

// File: rtl/fmt_slot.sv
module fmt_slot #(
  parameter int WORD_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                push,
  input  logic                wide_i,
  input  logic                zero_i,
  input  logic [2*WORD_W-1:0] re_i,
  input  logic [2*WORD_W-1:0] im_i,
  input  logic                pop,
  output logic                valid_o,
  output logic                wide_o,
  output logic                zero_o,
  output logic [2*WORD_W-1:0] re_o,
  output logic [2*WORD_W-1:0] im_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      wide_o  <= 1'b0;
      zero_o  <= 1'b0;
      re_o    <= '0;
      im_o    <= '0;
    end else if (push) begin
      valid_o <= 1'b1;
      wide_o  <= wide_i;
      zero_o  <= zero_i;
      re_o    <= re_i;
      im_o    <= im_i;
    end else if (pop) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/fmt_serializer.sv
module fmt_serializer
  import fmt_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                src_valid,
  input  logic                src_wide,
  input  logic                src_zero,
  input  logic [2*WORD_W-1:0] src_re,
  input  logic [2*WORD_W-1:0] src_im,
  output logic                src_take,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [WORD_W-1:0]   out_re,
  output logic [WORD_W-1:0]   out_im,
  output logic                out_hi,
  output logic                out_wide
);
  localparam int ACC_W = 2 * WORD_W;

  logic [NUM_LANES-1:0][ACC_W-1:0]  acc;
  logic [NUM_LANES-1:0][WORD_W-1:0] rnd;
  logic [NUM_LANES-1:0][WORD_W-1:0] first_w;
  logic [NUM_LANES-1:0][WORD_W-1:0] second_w;
  logic [NUM_LANES-1:0][WORD_W-1:0] lo_q;
  logic lo_pend;
  logic out_free;

  assign acc[0] = src_re;
  assign acc[1] = src_im;

  generate
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      fmt_rounder #(.WORD_W(WORD_W)) u_rnd (
        .acc_i  (acc[g]),
        .word_o (rnd[g])
      );
      always_comb begin
        if (src_zero) begin
          first_w[g]  = '0;
          second_w[g] = '0;
        end else if (src_wide) begin
          first_w[g]  = acc[g][ACC_W-1 -: WORD_W];
          second_w[g] = acc[g][WORD_W-1:0];
        end else begin
          first_w[g]  = rnd[g];
          second_w[g] = '0;
        end
      end
    end
  endgenerate

  assign out_free = !out_valid || out_ready;
  assign src_take = out_free && !lo_pend && src_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_hi    <= 1'b0;
      out_wide  <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
      lo_pend   <= 1'b0;
      lo_q      <= '0;
    end else if (out_free) begin
      if (lo_pend) begin
        out_valid <= 1'b1;
        out_hi    <= 1'b0;
        out_wide  <= 1'b1;
        out_re    <= lo_q[0];
        out_im    <= lo_q[1];
        lo_pend   <= 1'b0;
      end else if (src_valid) begin
        out_valid <= 1'b1;
        out_hi    <= src_wide;
        out_wide  <= src_wide;
        out_re    <= first_w[0];
        out_im    <= first_w[1];
        lo_pend   <= src_wide;
        lo_q      <= second_w;
      end else begin
        out_valid <= 1'b0;
        out_hi    <= 1'b0;
        out_wide  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dual_stream_fmt.sv
module dual_stream_fmt
  import fmt_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int ACC_W  = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_mode,
  input  logic              in_zero,
  input  logic [ACC_W-1:0]  in_re,
  input  logic [ACC_W-1:0]  in_im,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_re,
  output logic [WORD_W-1:0] out_im,
  output logic              out_hi,
  output logic              out_wide
);
  logic             s_valid, s_wide, s_zero, take, push;
  logic [ACC_W-1:0] s_re, s_im;

  assign in_ready = !s_valid || take;
  assign push     = in_valid && in_ready;

  fmt_slot #(.WORD_W(WORD_W)) u_slot (
    .clk     (clk),
    .rst     (rst),
    .push    (push),
    .wide_i  (mode_is_wide(in_mode)),
    .zero_i  (in_zero),
    .re_i    (in_re),
    .im_i    (in_im),
    .pop     (take),
    .valid_o (s_valid),
    .wide_o  (s_wide),
    .zero_o  (s_zero),
    .re_o    (s_re),
    .im_o    (s_im)
  );

  fmt_serializer #(.WORD_W(WORD_W)) u_ser (
    .clk       (clk),
    .rst       (rst),
    .src_valid (s_valid),
    .src_wide  (s_wide),
    .src_zero  (s_zero),
    .src_re    (s_re),
    .src_im    (s_im),
    .src_take  (take),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_re    (out_re),
    .out_im    (out_im),
    .out_hi    (out_hi),
    .out_wide  (out_wide)
  );
endmodule

// File: rtl/fmt_checker.sv
module fmt_checker #(
  parameter int WORD_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_re,
  input logic [WORD_W-1:0] out_im,
  input logic              out_hi,
  input logic              out_wide
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_re) && $stable(out_im) &&
       $stable(out_hi) && $stable(out_wide)));

  assert_low_follows_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_hi) |=> (out_valid && out_wide && !out_hi));

  assert_hi_is_wide_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_hi) |-> out_wide);

  assert_ready_when_empty_R8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);
endmodule

bind dual_stream_fmt fmt_checker #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_re    (out_re),
  .out_im    (out_im),
  .out_hi    (out_hi),
  .out_wide  (out_wide)
);

// File: tb/sim_dual_stream_fmt.sv
`timescale 1ns/1ps
module sim_dual_stream_fmt;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_mode = 2'b00;
  logic        in_zero = 1'b0;
  logic [47:0] in_re = '0, in_im = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_re, out_im;
  logic        out_hi, out_wide;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dual_stream_fmt u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_zero(in_zero), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_ready(out_ready), .out_re(out_re),
    .out_im(out_im), .out_hi(out_hi), .out_wide(out_wide)
  );

  // layout: [99:98] mode, [97] zero, [96] spare, [95:48] real, [47:0] imag
  localparam logic [99:0] VEC [8] = '{
    {2'b00, 1'b0, 1'b0, 48'h000001_800000, 48'h000001_7FFFFF},
    {2'b11, 1'b0, 1'b0, 48'h7FFFFF_800000, 48'hFFFFFF_800000},
    {2'b01, 1'b0, 1'b0, 48'h123456_789ABC, 48'hFEDCBA_987654},
    {2'b10, 1'b0, 1'b0, 48'h800000_000001, 48'h000000_FFFFFF},
    {2'b00, 1'b1, 1'b0, 48'h123456_FFFFFF, 48'h7FFFFF_800000},
    {2'b01, 1'b1, 1'b0, 48'hABCDEF_123456, 48'h135790_246801},
    {2'b00, 1'b0, 1'b0, 48'h800000_000000, 48'h800000_7FFFFF},
    {2'b10, 1'b0, 1'b0, 48'h000000_000000, 48'hFFFFFF_FFFFFF}
  };

  function automatic logic [23:0] ref_round(input logic [47:0] a);
    logic signed [48:0] s;
    logic signed [48:0] q;
    s = $signed({a[47], a}) + 49'sd8388608;
    q = s >>> 24;
    if (q > 49'sd8388607) return 24'h7FFFFF;
    return q[23:0];
  endfunction

  function automatic logic ref_wide(input logic [1:0] m);
    return (m == 2'b01) || (m == 2'b10);
  endfunction

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  // output monitor for streaming tests
  bit          mon_en = 0;
  int          rec_n = 0;
  logic [23:0] rec_re [16];
  logic [23:0] rec_im [16];
  logic        rec_hi [16];
  int          rec_cyc [16];
  always @(negedge clk) begin
    if (mon_en && out_valid && out_ready && rec_n < 16) begin
      rec_re[rec_n]  = out_re;
      rec_im[rec_n]  = out_im;
      rec_hi[rec_n]  = out_hi;
      rec_cyc[rec_n] = cyc;
      rec_n = rec_n + 1;
    end
  end

  task automatic load_vec(input logic [99:0] v);
    in_mode = v[99:98];
    in_zero = v[97];
    in_re   = v[95:48];
    in_im   = v[47:0];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      summary();
    end
  end

  int          exp_n;
  logic [23:0] e_re [16];
  logic [23:0] e_im [16];
  logic        e_hi [16];

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1 out_valid", 48'(out_valid), 48'd0);
    chk("R1 in_ready", 48'(in_ready), 48'd1);

    // table walk: one result at a time, output free
    for (int i = 0; i < 8; i++) begin
      logic [99:0] v;
      string tag;
      logic w, z;
      v = VEC[i];
      w = ref_wide(v[99:98]);
      z = v[97];
      tag = w ? (z ? "R6" : "R4 R5") : (z ? "R6" : ((i == 1) ? "R3" : "R2 R5"));
      @(posedge clk); #1;
      load_vec(v);
      in_valid = 1'b1;
      @(posedge clk); #1;
      in_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk({tag, " R9 valid"}, 48'(out_valid), 48'd1);
      chk({tag, " wide"}, 48'(out_wide), 48'(w));
      chk({tag, " hi"}, 48'(out_hi), 48'(w));
      chk({tag, " re0"}, 48'(out_re), z ? 48'd0 : (w ? 48'(v[95:72]) : 48'(ref_round(v[95:48]))));
      chk({tag, " im0"}, 48'(out_im), z ? 48'd0 : (w ? 48'(v[47:24]) : 48'(ref_round(v[47:0]))));
      if (w) begin
        @(posedge clk);
        @(negedge clk);
        chk({tag, " valid1"}, 48'(out_valid), 48'd1);
        chk({tag, " hi1"}, 48'(out_hi), 48'd0);
        chk({tag, " wide1"}, 48'(out_wide), 48'd1);
        chk({tag, " re1"}, 48'(out_re), z ? 48'd0 : 48'(v[71:48]));
        chk({tag, " im1"}, 48'(out_im), z ? 48'd0 : 48'(v[23:0]));
      end
      @(posedge clk);
      @(negedge clk);
      chk({tag, " idle after"}, 48'(out_valid), 48'd0);
    end

    // back-pressure: hold, slot full, ignored offer (R7, R9)
    @(posedge clk); #1;
    out_ready = 1'b0;
    load_vec(VEC[0]);
    in_valid = 1'b1;
    @(posedge clk); #1;
    load_vec(VEC[6]);
    @(posedge clk); #1;
    load_vec(VEC[3]);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 in_ready low when slot full", 48'(in_ready), 48'd0);
      chk("R7 held valid", 48'(out_valid), 48'd1);
      chk("R7 held re", 48'(out_re), 48'(ref_round(VEC[0][95:48])));
      chk("R7 held im", 48'(out_im), 48'(ref_round(VEC[0][47:0])));
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    rec_n = 0;
    mon_en = 1;
    out_ready = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    mon_en = 0;
    chk("R9 words after release", 48'(rec_n), 48'd2);
    chk("R9 first re", 48'(rec_re[0]), 48'(ref_round(VEC[0][95:48])));
    chk("R9 second re", 48'(rec_re[1]), 48'(ref_round(VEC[6][95:48])));
    chk("R9 second im", 48'(rec_im[1]), 48'(ref_round(VEC[6][47:0])));

    // mixed stream at full rate (R8, R4)
    begin
      int items [6] = '{0, 2, 3, 1, 6, 5};
      exp_n = 0;
      foreach (items[j]) begin
        logic [99:0] v;
        v = VEC[items[j]];
        if (ref_wide(v[99:98])) begin
          e_re[exp_n] = v[97] ? 24'd0 : v[95:72];
          e_im[exp_n] = v[97] ? 24'd0 : v[47:24];
          e_hi[exp_n] = 1'b1;
          exp_n++;
          e_re[exp_n] = v[97] ? 24'd0 : v[71:48];
          e_im[exp_n] = v[97] ? 24'd0 : v[23:0];
          e_hi[exp_n] = 1'b0;
          exp_n++;
        end else begin
          e_re[exp_n] = v[97] ? 24'd0 : ref_round(v[95:48]);
          e_im[exp_n] = v[97] ? 24'd0 : ref_round(v[47:0]);
          e_hi[exp_n] = 1'b0;
          exp_n++;
        end
      end
      rec_n = 0;
      mon_en = 1;
      @(posedge clk); #1;
      foreach (items[j]) begin
        load_vec(VEC[items[j]]);
        in_valid = 1'b1;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
      end
      in_valid = 1'b0;
      repeat (6) @(posedge clk);
      @(negedge clk);
      mon_en = 0;
      chk("R8 stream word count", 48'(rec_n), 48'(exp_n));
      for (int k = 0; k < exp_n; k++) begin
        chk("R8 stream re", 48'(rec_re[k]), 48'(e_re[k]));
        chk("R8 stream im", 48'(rec_im[k]), 48'(e_im[k]));
        chk("R4 stream hi flag", 48'(rec_hi[k]), 48'(e_hi[k]));
      end
      if (rec_n == exp_n)
        chk("R8 no idle cycles", 48'(rec_cyc[rec_n-1] - rec_cyc[0]), 48'(exp_n - 1));
    end

    // reset in the middle of a wide transfer returns to idle (R1)
    @(posedge clk); #1;
    out_ready = 1'b0;
    load_vec(VEC[2]);
    in_valid = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(posedge clk); #1;
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after reset", 48'(out_valid), 48'd0);
    chk("R1 in_ready after reset", 48'(in_ready), 48'd1);
    @(posedge clk);
    @(negedge clk);
    chk("R1 nothing left after reset", 48'(out_valid), 48'd0);

    done = 1;
    summary();
  end
endmodule